// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block lets on-chip logic run a three-wire serial EEPROM through a small command port. The user puts an operation code, an address and write data on the port, pulses `start_i`, and the controller produces chip select, shift clock and serial data, samples the memory's data line, and then reports completion. Every serial timing limit is met by counting system clock cycles. The counts come from the clock frequency and from nanosecond limits, all of which are parameters.

A read shifts the request out, drops the leading zero that the memory sends first, and returns the data word on `rdata_o`. Every command that changes the array ends with a status poll. Chip select goes low for the required gap, rises again, and the controller waits for the memory's data line to read 1. If that does not happen within the poll limit, `err_o` is set. The word organisation (16-bit words with 6 address bits, or 8-bit words with 7 address bits) is set by a parameter.

Top module: `sereep_host`

## Requirements
- R1: A command begins with chip select rising while DI already holds a 1 start bit. The next bits are two opcode bits and then the address field, most significant bit first. The opcode is 10 for read, 01 for write and 11 for single-word erase.
- R2: Erase-all, write-all, write-enable and write-disable send opcode 00. The two top address-field bits carry 10, 01, 11 and 00 respectively, and the remaining address-field bits are sent as clocked zeros.
- R3: For a read, the first bit sampled after the address is discarded. The next DW bits, most significant first, are returned on `rdata_o` in the cycle of `done_o`.
- R4: SK stays high for at least the SK half-period in system cycles, and stays low for at least the same count, measured from chip select rising. DI changes only while SK is low. SK is high only while chip select is high.
- R5: Chip select stays low for at least the chip-select gap count between any two high periods, and this includes the gap before a status poll.
- R6: After write, erase, erase-all or write-all, chip select is raised again with no SK activity. `done_o` follows only after DO has read 1 in that poll.
- R7: If DO does not read 1 within the poll limit, chip select goes low, and `done_o` then pulses with `err_o` high. `err_o` stays high until the next command is accepted.
- R8: `start_i` is accepted only while idle. A start pulse during a command produces no serial frame.
- R9: After reset, chip select, SK, `busy_o`, `done_o` and `err_o` are low. `busy_o` is high from the cycle after an accepted start until `done_o`, which is a one-cycle pulse with `busy_o` low.
- R10: `op_i` codes are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 enable and 6 disable. Code 7 acts as disable. Read, write and write-all frames carry 3+AW+DW bits, and all others carry 3+AW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, accepted when idle |
| op_i | input | 3 | Operation code (see R10) |
| addr_i | input | AW (6 or 7) | Word address |
| wdata_i | input | DW (16 or 8) | Data for write and write-all |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Status poll timed out |
| rdata_o | output | DW | Word returned by the last read |
| cs_o | output | 1 | Memory chip select |
| sk_o | output | 1 | Memory shift clock |
| di_o | output | 1 | Serial data to the memory |
| do_i | input | 1 | Serial data and ready status from the memory |

## Verification
The controller runs against a behavioural memory that decodes frames on SK rising edges. Every operation code is tried under both enabled and disabled write protection. Data words include all-ones, all-zeros, the 0x8001 edge pattern and mixed patterns, and addresses include 0 and the top address. Reading back after a write made while disabled distinguishes a correct frame encoding from a merely well-timed one. Reading back after erase-all and after write-all separates the prefix bits in the address field. A memory that never reports ready exercises the timeout path, and a second start pulse during a command exercises the idle-only acceptance.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_ER   = 3'd2,
    OP_ERAL = 3'd3,
    OP_WRAL = 3'd4,
    OP_EWEN = 3'd5,
    OP_EWDS = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_GAP, S_POLL
  } st_e;

  // round a nanosecond limit up to whole clock cycles, never below 2
  function automatic int ns2cyc(longint hz, longint ns);
    longint c;
    c = (hz * ns + 64'sd999_999_999) / 64'sd1_000_000_000;
    return (c < 2) ? 2 : int'(c);
  endfunction

  function automatic int addr_bits(bit org16);
    return org16 ? 6 : 7;
  endfunction

  function automatic int data_bits(bit org16);
    return org16 ? 16 : 8;
  endfunction

endpackage

// File: rtl/sereep_timer.sv
module sereep_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero && !load |=> zero); // R5

endmodule

// File: rtl/sereep_framer.sv
module sereep_framer import sereep_pkg::*; #(
  parameter  int AW = 6,
  parameter  int DW = 16,
  localparam int FW = 3 + AW + DW,
  localparam int NW = $clog2(FW + 1)
) (
  input  logic [2:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic [FW-1:0] frame,
  output logic [NW-1:0] nbits,
  output logic          is_rd,
  output logic          is_prog
);

  logic [1:0]    opc;
  logic [AW-1:0] af;
  logic [DW-1:0] dat;
  logic          long_f;

  always_comb begin
    opc = 2'b00; af = '0; dat = '0;
    is_rd = 1'b0; is_prog = 1'b0; long_f = 1'b0;
    case (op)
      OP_RD:   begin opc = 2'b10; af = addr; is_rd = 1'b1; long_f = 1'b1; end
      OP_WR:   begin opc = 2'b01; af = addr; dat = data; is_prog = 1'b1; long_f = 1'b1; end
      OP_ER:   begin opc = 2'b11; af = addr; is_prog = 1'b1; end
      OP_ERAL: begin af = {2'b10, {(AW-2){1'b0}}}; is_prog = 1'b1; end
      OP_WRAL: begin af = {2'b01, {(AW-2){1'b0}}}; dat = data; is_prog = 1'b1; long_f = 1'b1; end
      OP_EWEN: af = {2'b11, {(AW-2){1'b0}}};
      default: af = '0;
    endcase
    frame = {1'b1, opc, af, dat};
    nbits = long_f ? NW'(FW) : NW'(3 + AW);
  end

endmodule

// File: rtl/sereep_host.sv
module sereep_host import sereep_pkg::*; #(
  parameter  bit     ORG16         = 1'b1,
  parameter  longint CLK_HZ        = 50_000_000,
  parameter  longint SK_HALF_NS    = 250,
  parameter  longint CS_LOW_NS     = 250,
  parameter  longint POLL_LIMIT_NS = 12_000_000,
  localparam int     AW            = addr_bits(ORG16),
  localparam int     DW            = data_bits(ORG16)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic          cs_o,
  output logic          sk_o,
  output logic          di_o,
  input  logic          do_i
);

  localparam int FW   = 3 + AW + DW;
  localparam int NW   = $clog2(FW + 1);
  localparam int HALF = ns2cyc(CLK_HZ, SK_HALF_NS);
  localparam int CSL  = ns2cyc(CLK_HZ, CS_LOW_NS);
  localparam int TOC  = ns2cyc(CLK_HZ, POLL_LIMIT_NS);
  localparam int PMAX = (HALF > CSL) ? HALF : CSL;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int TW   = $clog2(TOC + 1);

  st_e           state;
  logic [FW-1:0] sh;
  logic [NW-1:0] bitn, nbits_q;
  logic          rd_q, prog_q, polled_q;
  logic [DW:0]   rx;

  logic [FW-1:0] f_frame;
  logic [NW-1:0] f_nbits;
  logic          f_rd, f_prog;

  sereep_framer #(.AW(AW), .DW(DW)) u_framer (
    .op(op_i), .addr(addr_i), .data(wdata_i),
    .frame(f_frame), .nbits(f_nbits), .is_rd(f_rd), .is_prog(f_prog)
  );

  logic          ph_load, ph_zero, to_load, to_zero;
  logic [PW-1:0] ph_val;

  sereep_timer #(.W(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .val(ph_val), .zero(ph_zero)
  );
  sereep_timer #(.W(TW)) u_limit (
    .clk(clk), .rst_n(rst_n), .load(to_load), .val(TW'(TOC - 1)), .zero(to_zero)
  );

  // named events, shared by the FSM and the assertions
  logic frame_start, half_end_lo, half_end_hi, bit_last, sample_en;
  logic gap_end, poll_enter, poll_ready, poll_expire, poll_phase;

  assign frame_start = (state == S_IDLE) && start_i;
  assign half_end_lo = (state == S_LO) && ph_zero;
  assign half_end_hi = (state == S_HI) && ph_zero;
  assign bit_last    = (bitn == nbits_q - 1'b1);
  assign sample_en   = half_end_hi && rd_q && (bitn >= NW'(3 + AW - 1));
  assign gap_end     = (state == S_GAP) && ph_zero;
  assign poll_enter  = gap_end && prog_q && !polled_q;
  assign poll_phase  = (state == S_POLL);
  assign poll_ready  = poll_phase && ph_zero && do_i;
  assign poll_expire = poll_phase && !poll_ready && to_zero;

  always_comb begin
    ph_load = 1'b0;
    ph_val  = PW'(HALF - 1);
    if (frame_start || half_end_lo || poll_enter) ph_load = 1'b1;
    if (half_end_hi) begin
      ph_load = 1'b1;
      if (bit_last) ph_val = PW'(CSL - 1);
    end
    if (poll_ready || poll_expire) begin
      ph_load = 1'b1;
      ph_val  = PW'(CSL - 1);
    end
  end
  assign to_load = poll_enter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sh <= '0; bitn <= '0; nbits_q <= '0;
      rd_q <= 1'b0; prog_q <= 1'b0; polled_q <= 1'b0; rx <= '0;
      cs_o <= 1'b0; sk_o <= 1'b0; di_o <= 1'b0;
      done_o <= 1'b0; err_o <= 1'b0; rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          cs_o <= 1'b1; di_o <= f_frame[FW-1]; sh <= f_frame << 1;
          bitn <= '0; nbits_q <= f_nbits; rd_q <= f_rd; prog_q <= f_prog;
          polled_q <= 1'b0; err_o <= 1'b0; state <= S_LO;
        end
        S_LO: if (ph_zero) begin
          sk_o <= 1'b1; state <= S_HI;
        end
        S_HI: if (ph_zero) begin
          sk_o <= 1'b0;
          if (sample_en) rx <= {rx[DW-1:0], do_i};
          if (bit_last) begin
            cs_o <= 1'b0; di_o <= 1'b0; state <= S_GAP;
          end else begin
            di_o <= sh[FW-1]; sh <= sh << 1; bitn <= bitn + 1'b1; state <= S_LO;
          end
        end
        S_GAP: if (ph_zero) begin
          if (poll_enter) begin
            cs_o <= 1'b1; polled_q <= 1'b1; state <= S_POLL;
          end else begin
            done_o <= 1'b1; state <= S_IDLE;
            if (rd_q) rdata_o <= rx[DW-1:0];
          end
        end
        S_POLL: if (poll_ready || poll_expire) begin
          cs_o <= 1'b0; state <= S_GAP;
          if (poll_expire) err_o <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state != S_IDLE);

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sk_o |-> cs_o); // R4
  AST_DI_STILL_WHILE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sk_o && $past(sk_o) |-> $stable(di_o)); // R4
  AST_DI_SETTLED_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk_o) |-> $stable(di_o)); // R4
  AST_FRAME_OPENS_WITH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) && !poll_phase |-> di_o); // R1
  AST_POLL_HAS_NO_SK: assert property (@(posedge clk) disable iff (!rst_n)
    poll_phase |-> !sk_o); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_ERR_RISES_IN_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !cs_o && $past(poll_phase)); // R7
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !frame_start |=> $stable(nbits_q)); // R8

endmodule

// File: tb/sereep_host_tb.sv
module sereep_host_tb;
  localparam int AW = 6, DW = 16, HALF = 13, CSL = 13, BUSYT = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start = 1'b0;
  logic [2:0]    op = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdat = '0;
  logic          busy, done, err, cs, sk, di;
  logic          m_do = 1'b0;
  logic [DW-1:0] rdata;

  sereep_host #(.ORG16(1'b1), .CLK_HZ(50_000_000), .POLL_LIMIT_NS(4000)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .wdata_i(wdat), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .cs_o(cs), .sk_o(sk), .di_o(di), .do_i(m_do)
  );

  int vecs = 0, miss = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct { logic [8:0] hdr; int nb; } fr_t;
  typedef struct { bit rd; logic [15:0] data; bit err; bit prog; } rs_t;
  fr_t fq[$];
  rs_t rq[$];
  fr_t fcur;
  rs_t rcur;

  // behavioural memory
  logic [15:0] mem [64];
  int          nbm = 0, bcnt = 0;
  logic [8:0]  hdr9, hv;
  logic [15:0] din, dv, rd_sh;
  logic        wen = 1'b0, stuck = 1'b0, rd_act = 1'b0, sk_q = 1'b0, cs_q = 1'b0;

  initial for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;

  always @(posedge clk) begin
    sk_q <= sk; cs_q <= cs;
    if (bcnt > 0 && !stuck) bcnt <= bcnt - 1;
    if (cs_q && !cs && nbm > 0) begin
      if (fq.size() == 0) chk(1'b0, "R8 unexpected frame", hdr9, 0);
      else begin
        fcur = fq.pop_front();
        chk(hdr9 == fcur.hdr, "R1 R2 R10 frame header", hdr9, fcur.hdr);
        chk(nbm == fcur.nb, "R10 frame length", nbm, fcur.nb);
      end
    end
    if (!cs) begin
      nbm <= 0; rd_act <= 1'b0; m_do <= 1'b0;
    end else if (sk && !sk_q) begin
      hv = (nbm < 9) ? {hdr9[7:0], di} : hdr9;
      dv = (nbm >= 9) ? {din[14:0], di} : din;
      hdr9 <= hv; din <= dv; nbm <= nbm + 1;
      if (nbm == 8) begin
        case (hv[7:6])
          2'b10: begin rd_sh <= mem[hv[5:0]]; m_do <= 1'b0; rd_act <= 1'b1; end
          2'b11: if (wen) begin mem[hv[5:0]] <= 16'hFFFF; bcnt <= BUSYT; end
          2'b00: case (hv[5:4])
            2'b11: wen <= 1'b1;
            2'b00: wen <= 1'b0;
            2'b10: if (wen) begin
              for (int i = 0; i < 64; i++) mem[i] <= 16'hFFFF;
              bcnt <= BUSYT;
            end
            default: ;
          endcase
          default: ;
        endcase
      end else if (rd_act) begin
        m_do <= rd_sh[15]; rd_sh <= rd_sh << 1;
      end
      if (nbm == 24 && wen) begin
        if (hv[7:6] == 2'b01) begin mem[hv[5:0]] <= dv; bcnt <= BUSYT; end
        else if (hv[7:4] == 4'b0001) begin
          for (int i = 0; i < 64; i++) mem[i] <= dv;
          bcnt <= BUSYT;
        end
      end
    end else if (nbm == 0) m_do <= (bcnt == 0);
  end

  // result monitor
  always @(negedge clk) if (rst_n && done) begin
    if (rq.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
    else begin
      rcur = rq.pop_front();
      chk(err == rcur.err, "R7 error flag at done", err, rcur.err);
      chk(!busy && !cs, "R9 idle at done", {busy, cs}, 0);
      if (rcur.rd) chk(rdata == rcur.data, "R3 read word", rdata, rcur.data);
      if (rcur.prog && !rcur.err) chk(bcnt == 0, "R6 done only after ready", bcnt, 0);
    end
  end

  // timing monitor
  int hi_run = 0, lo_run = 0, cl_run = 0, min_hi = 1000, min_lo = 1000, min_cl = 1000, bad_di = 0;
  bit seen_cs = 0;
  logic sk_p = 1'b0, di_p = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (sk) hi_run++;
    else begin if (hi_run > 0 && hi_run < min_hi) min_hi = hi_run; hi_run = 0; end
    if (cs && !sk) lo_run++;
    else if (sk) begin if (lo_run > 0 && lo_run < min_lo) min_lo = lo_run; lo_run = 0; end
    else lo_run = 0;
    if (!cs) cl_run++;
    else begin
      if (seen_cs && cl_run > 0 && cl_run < min_cl) min_cl = cl_run;
      seen_cs = 1; cl_run = 0;
    end
    if (sk && sk_p && di != di_p) bad_di++;
    if (sk && !cs) bad_di++;
    sk_p = sk; di_p = di;
  end

  // shadow state for expectations
  logic [15:0] s_mem [64];
  bit s_wen = 0;
  initial for (int i = 0; i < 64; i++) s_mem[i] = 16'hFFFF;

  function automatic logic [8:0] bhdr(input logic [2:0] o, input logic [5:0] a);
    case (o)
      3'd0: return {3'b110, a};
      3'd1: return {3'b101, a};
      3'd2: return {3'b111, a};
      3'd3: return 9'b100_100000;
      3'd4: return 9'b100_010000;
      3'd5: return 9'b100_110000;
      default: return 9'b100_000000;
    endcase
  endfunction

  task automatic expect_cmd(input logic [2:0] o, input logic [5:0] a, input logic [15:0] d, input bit e);
    fr_t f; rs_t r;
    f.hdr = bhdr(o, a);
    f.nb  = (o == 3'd0 || o == 3'd1 || o == 3'd4) ? 25 : 9;
    fq.push_back(f);
    r.rd = (o == 3'd0); r.data = s_mem[a]; r.err = e;
    r.prog = (o >= 3'd1 && o <= 3'd4);
    rq.push_back(r);
    case (o)
      3'd1: if (s_wen) s_mem[a] = d;
      3'd2: if (s_wen) s_mem[a] = 16'hFFFF;
      3'd3: if (s_wen) for (int i = 0; i < 64; i++) s_mem[i] = 16'hFFFF;
      3'd4: if (s_wen) for (int i = 0; i < 64; i++) s_mem[i] = d;
      3'd5: s_wen = 1;
      3'd0: ;
      default: s_wen = 0;
    endcase
  endtask

  task automatic issue(input logic [2:0] o, input logic [5:0] a, input logic [15:0] d, input bit e = 0);
    expect_cmd(o, a, d, e);
    @(negedge clk);
    start = 1'b1; op = o; addr = a; wdat = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk({cs, sk, busy, done, err} == 5'b0, "R9 reset state", {cs, sk, busy, done, err}, 0);
    rst_n = 1'b1;
    issue(3'd1, 6'd5, 16'hA5C3);       // R6 write while protected, no effect
    issue(3'd0, 6'd5, 16'h0);          // R3 reads back erased value
    issue(3'd5, 6'd0, 16'h0);          // R2 enable
    issue(3'd1, 6'd5, 16'hA5C3);
    issue(3'd0, 6'd5, 16'h0);
    issue(3'd1, 6'd63, 16'h8001);      // R1 top address
    issue(3'd0, 6'd63, 16'h0);
    issue(3'd1, 6'd0, 16'h0000);
    issue(3'd0, 6'd0, 16'h0);
    issue(3'd2, 6'd5, 16'h0);          // R1 erase
    issue(3'd0, 6'd5, 16'h0);
    issue(3'd4, 6'd0, 16'h1234);       // R2 write-all
    issue(3'd0, 6'd0, 16'h0);
    issue(3'd0, 6'd40, 16'h0);
    issue(3'd3, 6'd0, 16'h0);          // R2 erase-all
    issue(3'd0, 6'd17, 16'h0);
    issue(3'd6, 6'd0, 16'h0);          // R2 disable
    issue(3'd1, 6'd3, 16'h5555);
    issue(3'd0, 6'd3, 16'h0);
    issue(3'd5, 6'd0, 16'h0);
    issue(3'd7, 6'd0, 16'h0);          // R10 code 7 acts as disable
    issue(3'd1, 6'd3, 16'h5555);
    issue(3'd0, 6'd3, 16'h0);
    issue(3'd5, 6'd0, 16'h0);
    stuck = 1'b1;                      // R7 memory never ready
    issue(3'd1, 6'd9, 16'h0F0F, 1'b1);
    chk(err == 1'b1, "R7 error held after done", err, 1);
    chk(cs == 1'b0, "R7 chip select low after timeout", cs, 0);
    stuck = 1'b0;
    repeat (BUSYT + 2) @(negedge clk);
    issue(3'd0, 6'd9, 16'h0);          // R7 error clears on next command
    // R8: second start during a command
    expect_cmd(3'd1, 6'd12, 16'hBEEF, 1'b0);
    @(negedge clk); start = 1'b1; op = 3'd1; addr = 6'd12; wdat = 16'hBEEF;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; op = 3'd0; addr = 6'd40;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R8 stray start left idle", busy, 0);
    issue(3'd0, 6'd12, 16'h0);
    chk(min_hi >= HALF, "R4 SK high time", min_hi, HALF);
    chk(min_lo >= HALF, "R4 SK low time", min_lo, HALF);
    chk(bad_di == 0, "R4 DI moved with SK high", bad_di, 0);
    chk(min_cl >= CSL, "R5 chip select gap", min_cl, CSL);
    chk(fq.size() == 0 && rq.size() == 0, "R8 scoreboard drained", fq.size() + rq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule